// File: doc/BRIEF.md
# Inter-Socket Link Event Counter Unit

This block is a performance monitoring unit for a serial link between sockets. It has eight independent 64-bit event counters. Each counter has its own configuration word. The word chooses one of up to 512 single-bit event strobes and says how that strobe is counted: once per transition, or on every cycle it sits at a chosen level. A single shared control word gates all counters together and can clear them. The event strobes come from the link logic as one flat vector, indexed by event ID.

Software reaches the unit through a 32-bit register port. A 64-bit count cannot be read in one bus access. Software therefore writes a selector value, and that write captures the chosen counter into a 64-bit snapshot. Two later word reads, low word then high word, return that single captured value, even while counting goes on.

Top module: `link_evt_pmu`

## Requirements
- R1: After reset, every counter is zero, and reads of the control word (0x108), every configuration word, the selector (0x12C) and both data windows (0x130, 0x134) return zero.
- R2: A counter advances only while both control bit 0 (enable) and control bit 1 (start) are set. Writing the control word with either bit clear holds every count. Setting both bits again resumes counting from the held value.
- R3: A control write with bit 4 set clears all counters in the cycle of that write, and this clear takes priority over any increment. Bit 4 is not stored and always reads back as 0. A write of 0x13 therefore starts counting from zero.
- R4: The configuration word of counter n sits at 0x10C + 4*n, for n = 0..7. Bits [9:0] hold the event ID, bit 10 is the polarity and bit 11 selects edge mode. Reads return bits [11:0] as written and zero above them.
- R5: In edge mode (bit 11 = 1), a counter advances once for each transition of its event line between consecutive cycles. With bit 10 = 1 it counts 0-to-1 transitions, and with bit 10 = 0 it counts 1-to-0 transitions.
- R6: In level mode (bit 11 = 0), a counter advances on every counting cycle in which its event line equals bit 10. A line held high for k cycles gives k counts with bit 10 = 1. A line held low for k cycles gives k counts with bit 10 = 0.
- R7: An event ID of 0x200 or above never causes a count, in any mode or polarity.
- R8: Each counter follows only its own configuration. Several counters may select the same event line in different modes, and each then gives its own result.
- R9: Writing 8 + n to the selector captures the current 64-bit value of counter n. Offset 0x130 then reads bits [31:0] of the capture and 0x134 reads bits [63:32]. The capture changes only on a selector write.
- R10: A selector value outside 8..15 makes both data windows read zero. The selector reads back the last value written to it. A read of any unmapped offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; rdata is updated at the next clock edge |
| addr | input | 12 | Byte offset of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| evt_i | input | 512 | Event strobes, bit i is event ID i |

## Verification
The bench builds the unit with its default parameters: eight 64-bit counters and 512 event lines. At this size it can reach the real example event IDs, the invalid boundary at ID 0x200 and every selector value from 7 to 16. Several counters share one event line in different modes, so the counts in edge and level mode can be compared against each other. A carry into the high data word would need more than 2^32 events, which is out of reach in a bench run. The high window is therefore checked only for its zero value and for its out-of-range behaviour.

// File: rtl/link_evt_pkg.sv
package link_evt_pkg;
  localparam int EVT_ID_W = 10;
  localparam int CFG_W    = 12;

  localparam logic [11:0] CTRL_OFS = 12'h108;
  localparam logic [11:0] CFG_BASE = 12'h10C;
  localparam logic [11:0] SEL_OFS  = 12'h12C;
  localparam logic [11:0] DLO_OFS  = 12'h130;
  localparam logic [11:0] DHI_OFS  = 12'h134;

  localparam int SEL_BASE  = 8;
  localparam int EN_BIT    = 0;
  localparam int START_BIT = 1;
  localparam int CLR_BIT   = 4;

  typedef struct packed {
    logic                edge_mode;
    logic                polarity;
    logic [EVT_ID_W-1:0] evt_id;
  } cfg_t;
endpackage

// File: rtl/link_evt_ctr.sv
module link_evt_ctr
  import link_evt_pkg::*;
#(
  parameter int NUM_EVT = 512,
  parameter int CTR_W   = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  cfg_t               cfg_wdata,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               run_i,
  input  logic               clr_i,
  output cfg_t               cfg_o,
  output logic [CTR_W-1:0]   cnt_o
);
  localparam int PAD_W = 2 ** EVT_ID_W;

  cfg_t             cfg_q, cfg_d;
  logic [CTR_W-1:0] cnt_q, cnt_d;
  logic             prev_q, prev_d;
  logic [PAD_W-1:0] evt_pad;
  logic             id_ok, line_now, hit;

  always_comb begin
    evt_pad  = PAD_W'(evt_i);
    id_ok    = (32'(cfg_q.evt_id) < NUM_EVT);
    line_now = id_ok & evt_pad[cfg_q.evt_id];
    if (cfg_q.edge_mode)
      hit = cfg_q.polarity ? (line_now & ~prev_q) : (~line_now & prev_q);
    else
      hit = (line_now == cfg_q.polarity);
    hit    = hit & id_ok;
    prev_d = line_now;
    cfg_d  = cfg_we ? cfg_wdata : cfg_q;
    if (clr_i)
      cnt_d = '0;
    else if (run_i && hit)
      cnt_d = cnt_q + 1'b1;
    else
      cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      cnt_q  <= '0;
      prev_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      if (cfg_we) cfg_q <= cfg_d;
      if (clr_i || (run_i && hit)) cnt_q <= cnt_d;
    end
  end

  assign cfg_o = cfg_q;
  assign cnt_o = cnt_q;

  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !clr_i) |=> $stable(cnt_q));

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));

  assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (cnt_q == $past(cnt_q) || cnt_q == CTR_W'($past(cnt_q) + 1'b1)));

  assert_bad_id_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !id_ok) |=> $stable(cnt_q));
endmodule

// File: rtl/link_evt_snap.sv
module link_evt_snap
  import link_evt_pkg::*;
#(
  parameter int NUM_CTR = 8,
  parameter int CTR_W   = 64,
  parameter int DATA_W  = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sel_we,
  input  logic [DATA_W-1:0]             sel_wdata,
  input  logic [NUM_CTR-1:0][CTR_W-1:0] cnt_i,
  output logic [DATA_W-1:0]             sel_o,
  output logic [CTR_W-1:0]              snap_o
);
  localparam int IDX_W = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1;

  logic [DATA_W-1:0] sel_q, sel_d;
  logic [CTR_W-1:0]  snap_q, snap_d;
  logic              in_range;
  logic [IDX_W-1:0]  idx;

  always_comb begin
    in_range = (sel_wdata >= DATA_W'(SEL_BASE)) &&
               (sel_wdata <  DATA_W'(SEL_BASE + NUM_CTR));
    idx      = IDX_W'(sel_wdata - DATA_W'(SEL_BASE));
    sel_d    = sel_we ? sel_wdata : sel_q;
    if (!sel_we)
      snap_d = snap_q;
    else if (in_range)
      snap_d = cnt_i[idx];
    else
      snap_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      snap_q <= '0;
    end else if (sel_we) begin
      sel_q  <= sel_d;
      snap_q <= snap_d;
    end
  end

  assign sel_o  = sel_q;
  assign snap_o = snap_q;

  assert_snap_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_we |=> $stable(snap_q));

  assert_bad_sel_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_we && !in_range) |=> (snap_q == '0));
endmodule

// File: rtl/link_evt_pmu.sv
module link_evt_pmu
  import link_evt_pkg::*;
#(
  parameter int NUM_CTR = 8,
  parameter int CTR_W   = 64,
  parameter int NUM_EVT = 512,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic [NUM_EVT-1:0] evt_i
);
  localparam int SNAP_W = 2 * DATA_W;

  logic                          en_q, en_d, start_q, start_d;
  logic                          ctrl_we, sel_we, clr, run;
  logic [NUM_CTR-1:0]            cfg_we;
  cfg_t                          cfg_rd [NUM_CTR];
  logic [NUM_CTR-1:0][CTR_W-1:0] cnt;
  logic [DATA_W-1:0]             sel_val;
  logic [CTR_W-1:0]              snap;
  logic [SNAP_W-1:0]             snap_ext;
  logic [DATA_W-1:0]             rd_d, rdata_q;

  always_comb begin
    ctrl_we = wr_en && (addr == ADDR_W'(CTRL_OFS));
    sel_we  = wr_en && (addr == ADDR_W'(SEL_OFS));
    clr     = ctrl_we && wdata[CLR_BIT];
    en_d    = ctrl_we ? wdata[EN_BIT]    : en_q;
    start_d = ctrl_we ? wdata[START_BIT] : start_q;
    run     = en_q & start_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      start_q <= 1'b0;
    end else if (ctrl_we) begin
      en_q    <= en_d;
      start_q <= start_d;
    end
  end

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    assign cfg_we[i] = wr_en && (addr == ADDR_W'(CFG_BASE + 12'(4 * i)));
    link_evt_ctr #(.NUM_EVT(NUM_EVT), .CTR_W(CTR_W)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we[i]),
      .cfg_wdata (cfg_t'(wdata[CFG_W-1:0])),
      .evt_i     (evt_i),
      .run_i     (run),
      .clr_i     (clr),
      .cfg_o     (cfg_rd[i]),
      .cnt_o     (cnt[i])
    );
  end

  link_evt_snap #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .DATA_W(DATA_W)) u_snap (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_we    (sel_we),
    .sel_wdata (wdata),
    .cnt_i     (cnt),
    .sel_o     (sel_val),
    .snap_o    (snap)
  );

  always_comb begin
    snap_ext = SNAP_W'(snap);
    rd_d     = '0;
    if (addr == ADDR_W'(CTRL_OFS)) begin
      rd_d[EN_BIT]    = en_q;
      rd_d[START_BIT] = start_q;
    end
    if (addr == ADDR_W'(SEL_OFS)) rd_d = sel_val;
    if (addr == ADDR_W'(DLO_OFS)) rd_d = snap_ext[DATA_W-1:0];
    if (addr == ADDR_W'(DHI_OFS)) rd_d = snap_ext[SNAP_W-1:DATA_W];
    for (int i = 0; i < NUM_CTR; i++)
      if (addr == ADDR_W'(CFG_BASE + 12'(4 * i))) rd_d = DATA_W'(cfg_rd[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_d;
  end

  assign rdata = rdata_q;

  assert_ctrl_clr_not_stored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(CTRL_OFS)) |=> (rdata[CLR_BIT] == 1'b0));

  assert_cfg_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(CFG_BASE)) |=> (rdata[DATA_W-1:CFG_W] == '0));
endmodule

// File: tb/link_evt_pmu_test.sv
module link_evt_pmu_test;
  logic        clk, rst_n, wr_en, rd_en;
  logic [11:0] addr;
  logic [31:0] wdata, rdata;
  logic [511:0] evt;
  int checks, errors;

  link_evt_pmu uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .evt_i(evt)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic rd_ctr(input int n, output logic [31:0] lo, output logic [31:0] hi);
    wr(12'h12C, 32'(8 + n));
    rd(12'h130, lo);
    rd(12'h134, hi);
  endtask

  task automatic pulse(input int id, input int hi, input int lo, input int n);
    for (int k = 0; k < n; k++) begin
      evt[id] = 1'b1;
      repeat (hi) @(negedge clk);
      evt[id] = 1'b0;
      repeat (lo) @(negedge clk);
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(12'h108, d); check("R1 ctrl", d, 0);
    rd(12'h10C, d); check("R1 cfg0", d, 0);
    rd(12'h128, d); check("R1 cfg7", d, 0);
    rd(12'h12C, d); check("R1 sel", d, 0);
    rd(12'h130, d); check("R1 lo", d, 0);
    rd(12'h134, d); check("R1 hi", d, 0);
  endtask

  task automatic t_modes;
    logic [31:0] lo, hi, d;
    wr(12'h10C, 32'hC3D);
    wr(12'h110, 32'h43D);
    wr(12'h114, 32'h865);
    wr(12'h118, 32'h105);
    wr(12'h11C, 32'hD2D);
    wr(12'h120, 32'h200);
    wr(12'h124, 32'h52D);
    wr(12'h128, 32'h400);
    rd(12'h118, d); check("R4 cfg3 readback", d, 32'h105);
    rd(12'h11C, d); check("R4 cfg4 readback", d, 32'hD2D);
    @(negedge clk); evt[12'h105] = 1'b1;
    wr(12'h108, 32'h13);
    rd(12'h108, d); check("R3 ctrl reads 0x03", d, 3);
    pulse(12'h3D, 2, 3, 5);
    pulse(12'h65, 1, 2, 3);
    evt[12'h105] = 1'b0; repeat (4) @(negedge clk); evt[12'h105] = 1'b1;
    pulse(12'h12D, 3, 2, 2);
    repeat (3) @(negedge clk);
    wr(12'h108, 32'h0);
    rd_ctr(0, lo, hi); check("R5 rising edges", lo, 5); check("R9 hi word", hi, 0);
    rd_ctr(1, lo, hi); check("R6 level high", lo, 10);
    rd_ctr(2, lo, hi); check("R5 falling edges", lo, 3);
    rd_ctr(3, lo, hi); check("R6 level low", lo, 4);
    rd_ctr(4, lo, hi); check("R8 second rising counter", lo, 2);
    rd_ctr(5, lo, hi); check("R7 invalid id", lo, 0); check("R7 invalid id hi", hi, 0);
    rd_ctr(6, lo, hi); check("R8 level high other line", lo, 6);
    rd_ctr(7, lo, hi); check("R8 idle line", lo, 0);
  endtask

  task automatic t_gating;
    logic [31:0] lo, hi;
    wr(12'h108, 32'h1);
    pulse(12'h3D, 2, 2, 3);
    wr(12'h108, 32'h2);
    pulse(12'h3D, 2, 2, 2);
    wr(12'h108, 32'h0);
    rd_ctr(1, lo, hi); check("R2 enable or start alone holds", lo, 10);
    wr(12'h108, 32'h3);
    pulse(12'h3D, 2, 2, 2);
    wr(12'h108, 32'h0);
    rd_ctr(1, lo, hi); check("R2 resume accumulates level", lo, 14);
    rd_ctr(0, lo, hi); check("R2 resume accumulates edge", lo, 7);
    rd_ctr(3, lo, hi); check("R2 level-low held while line high", lo, 4);
  endtask

  task automatic t_clear;
    logic [31:0] lo, hi, d;
    wr(12'h108, 32'h10);
    for (int n = 0; n < 8; n++) begin
      rd_ctr(n, lo, hi);
      check($sformatf("R3 cleared ctr%0d", n), {hi, lo}, 0);
    end
    rd(12'h108, d); check("R3 ctrl after clear", d, 0);
    wr(12'h108, 32'h13);
    pulse(12'h3D, 1, 2, 1);
    wr(12'h108, 32'h0);
    rd_ctr(0, lo, hi); check("R3 count from zero", lo, 1);
  endtask

  task automatic t_snapshot;
    logic [31:0] a, b, c;
    @(negedge clk); evt[12'h3D] = 1'b1;
    wr(12'h108, 32'h3);
    repeat (3) @(negedge clk);
    wr(12'h12C, 32'd9);
    rd(12'h130, a);
    repeat (6) @(negedge clk);
    rd(12'h130, b);
    check("R9 snapshot stable while counting", b, a);
    wr(12'h12C, 32'd9);
    rd(12'h130, c);
    check("R9 new snapshot larger", 64'(c > a), 1);
    wr(12'h108, 32'h0);
    evt[12'h3D] = 1'b0;
  endtask

  task automatic t_badsel;
    logic [31:0] d;
    wr(12'h12C, 32'd7);
    rd(12'h130, d); check("R10 sel 7 lo", d, 0);
    rd(12'h134, d); check("R10 sel 7 hi", d, 0);
    wr(12'h12C, 32'd16);
    rd(12'h130, d); check("R10 sel 16 lo", d, 0);
    rd(12'h12C, d); check("R10 sel readback", d, 16);
    rd(12'h200, d); check("R10 unmapped", d, 0);
    wr(12'h128, 32'hFFFF_FFFF);
    rd(12'h128, d); check("R4 cfg field width", d, 32'hFFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; evt = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_modes;
    t_gating;
    t_clear;
    t_snapshot;
    t_badsel;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule